// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a stereo audio stream on three lines: a bit clock, a frame clock and a serial data line. It assembles the stream into a parallel left sample and a parallel right sample. The block runs entirely on the bit clock. The frame clock and data are sampled on each rising edge of that clock.

A two-bit framing code selects one of four framings:

- left-justified
- I2S
- right-justified
- DSP word-sync

A separate two-bit width code sets the sample length to 16, 20 or 24 bits. The width code is needed because a right-justified frame does not reveal where its data begins.

Samples arrive MSB first in two's complement. They are presented sign-extended to 24 bits, and a single-cycle valid pulse marks each completed stereo pair. The bit clock runs at 64 times the sample rate, so each channel slot is 32 bits long.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and after its release, `valid_o` is 0 and both sample outputs are 0 until the first stereo pair is complete.
- R2: With `fmt_i` = 2'b10 (left-justified), a frame starts when `lrck_i` is first sampled low after being high. The left MSB is the data bit sampled on that same edge. The right MSB is sampled 32 bit clocks later.
- R3: With `fmt_i` = 2'b01 (I2S), a frame starts when `lrck_i` is first sampled high after being low. The left MSB is the data bit sampled one bit clock after that edge. The right MSB is sampled 32 bit clocks after the left MSB.
- R4: With `fmt_i` = 2'b00 (right-justified), each channel word occupies the last N bits of its 32-bit slot, and a frame starts when `lrck_i` falls. Width code 2'b00 gives N = 24.
- R5: With `fmt_i` = 2'b11 (DSP), a frame starts on the first high sample of `lrck_i` after a low one. The left MSB is sampled on that edge, and the right word follows the left LSB directly.
- R6: Width code 2'b00 or 2'b11 selects 24 bits, 2'b01 selects 20 bits and 2'b10 selects 16 bits. A shorter word is sign-extended from its MSB to 24 bits.
- R7: `valid_o` is high for exactly one cycle after the edge that samples the right LSB. Both outputs then show the new pair, and they hold their values between pulses.
- R8: No valid pulse occurs before the first frame start after reset. Data bits seen before that start have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_i | input | 2 | Framing code: 10 left-justified, 01 I2S, 00 right-justified, 11 DSP |
| wcode_i | input | 2 | Width code: 00/11 24 bits, 01 20 bits, 10 16 bits |
| lrck_i | input | 1 | Frame clock or DSP sync pulse |
| sdat_i | input | 1 | Serial data, MSB first |
| left_o | output | 24 | Last left sample, sign-extended |
| right_o | output | 24 | Last right sample, sign-extended |
| valid_o | output | 1 | One-cycle pulse marking a new stereo pair |

## Verification
In right-justified framing, two events coincide: the right LSB is captured on the last bit of a frame, and the frame clock falls for the next frame on the following sample. The valid pulse of one frame is therefore visible in the same cycle that the next frame's first bit enters the shifter.

The bench drives frames back to back, with different samples and random filler bits around the data. It compares valid and both outputs against its own layout model on every cycle. A capture that is off by one bit, or that is disturbed by the restart, shows up as a wrong sample or as a pulse in the wrong cycle.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int DW   = 24,
  parameter int SLOT = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fmt_i,
  input  logic [1:0]    wcode_i,
  input  logic          lrck_i,
  input  logic          sdat_i,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o,
  output logic          valid_o
);
  localparam int CW = $clog2(2*SLOT);
  localparam logic [CW-1:0] SLOTC = CW'(SLOT);
  localparam logic [1:0] F_RJ = 2'b00, F_I2S = 2'b01, F_LJ = 2'b10, F_DSP = 2'b11;

  logic          lr_q, primed, synced;
  logic [CW-1:0] fc_q, idx, nbits, base, li, ri;
  logic [DW-1:0] sh, shn, word, left_hold;
  logic          fs, live;

  assign nbits = (wcode_i == 2'b01) ? CW'(20) : (wcode_i == 2'b10) ? CW'(16) : CW'(24);
  assign fs    = primed & (fmt_i[0] ? (!lr_q & lrck_i) : (lr_q & !lrck_i));
  assign idx   = fs ? '0 : fc_q + 1'b1;
  assign live  = synced | fs;
  assign base  = (fmt_i == F_I2S) ? CW'(1) : (fmt_i == F_RJ) ? SLOTC - nbits : '0;
  assign li    = base + nbits - 1'b1;
  assign ri    = li + ((fmt_i == F_DSP) ? nbits : SLOTC);
  assign shn   = {sh[DW-2:0], sdat_i};

  always_comb begin
    case (wcode_i)
      2'b01:   word = {{(DW-20){shn[19]}}, shn[19:0]};
      2'b10:   word = {{(DW-16){shn[15]}}, shn[15:0]};
      default: word = shn;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_q      <= 1'b0;
      primed    <= 1'b0;
      synced    <= 1'b0;
      fc_q      <= '0;
      sh        <= '0;
      left_hold <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      lr_q    <= lrck_i;
      primed  <= 1'b1;
      synced  <= live;
      fc_q    <= idx;
      sh      <= shn;
      valid_o <= 1'b0;
      if (live && idx == li) left_hold <= word;
      if (live && idx == ri) begin
        left_o  <= left_hold;
        right_o <= word;
        valid_o <= 1'b1;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R7
  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> !valid_o); // R8
  AST_SEXT_16: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(wcode_i) == 2'b10) |-> (&right_o[DW-1:15] || ~|right_o[DW-1:15])); // R6
  AST_SEXT_20: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(wcode_i) == 2'b01) |-> (&right_o[DW-1:19] || ~|right_o[DW-1:19])); // R6
endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  fmt = 2'b10, wcode = 2'b00;
  logic        lrck = 1'b0, sdat = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  serial_audio_rx u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .wcode_i(wcode),
    .lrck_i(lrck), .sdat_i(sdat),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [23:0] exp_l = '0, exp_r = '0;
  logic        exp_v = 1'b0;
  string       cur_req = "R1";
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [23:0] sx(input logic [23:0] v, input int n);
    logic [23:0] m;
    m = v & ((24'h1 << n) - 24'h1);
    if (n < 24 && m[n-1]) m = m | (24'hFFFFFF << n);
    return m;
  endfunction

  function automatic int width_of(input logic [1:0] w);
    return (w == 2'b01) ? 20 : (w == 2'b10) ? 16 : 24;
  endfunction

  task automatic step(input logic lr, input logic d, input bit fire, input logic [23:0] fl, input logic [23:0] fr);
    @(negedge clk);
    chk(valid_o == exp_v, exp_v ? "R7" : "R7/R8 idle", {47'd0, valid_o}, {47'd0, exp_v});
    chk(left_o == exp_l && right_o == exp_r, cur_req, {left_o, right_o}, {exp_l, exp_r});
    exp_v = fire;
    if (fire) begin exp_l = fl; exp_r = fr; end
    lrck = lr;
    sdat = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    exp_v = 1'b0; exp_l = '0; exp_r = '0;
    repeat (2) @(negedge clk);
    cur_req = "R1";
    chk(valid_o == 1'b0 && left_o == '0 && right_o == '0, "R1", {left_o, right_o}, 48'd0);
    rst_n = 1'b1;
  endtask

  task automatic frame(input logic [23:0] l, input logic [23:0] r);
    int n, ls, rs;
    n = width_of(wcode);
    case (fmt)
      2'b10:   begin ls = 0;      rs = 32; end
      2'b01:   begin ls = 1;      rs = 33; end
      2'b00:   begin ls = 32 - n; rs = 64 - n; end
      default: begin ls = 0;      rs = n; end
    endcase
    for (int k = 0; k < 64; k++) begin
      logic lr, d;
      bit fire;
      case (fmt)
        2'b10, 2'b00: lr = (k >= 32);
        2'b01:        lr = (k < 32);
        default:      lr = (k == 0);
      endcase
      if (k >= ls && k < ls + n)      d = l[n-1-(k-ls)];
      else if (k >= rs && k < rs + n) d = r[n-1-(k-rs)];
      else                            d = 1'($urandom);
      fire = (k == rs + n - 1);
      step(lr, d, fire, sx(l, n), sx(r, n));
    end
  endtask

  task automatic group(input logic [1:0] f, input logic [1:0] w, input string req,
                       input logic [23:0] a, input logic [23:0] b, input logic [23:0] c);
    fmt = f; wcode = w;
    lrck = f[0] ? 1'b0 : 1'b1;
    do_reset();
    cur_req = "R8";
    for (int i = 0; i < 7; i++) step(f[0] ? 1'b0 : 1'b1, 1'($urandom), 1'b0, '0, '0);
    cur_req = req;
    frame(a, b);
    frame(c, ~a);
    frame(24'h7FFFFF, 24'h800000);
    frame(24'h000001, 24'hFFFFFF);
    for (int i = 0; i < 4; i++) step(f[0] ? 1'b1 : 1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0 && left_o == '0 && right_o == '0, "R1", {left_o, right_o}, 48'd0);
    group(2'b10, 2'b00, "R2 left-justified 24", 24'hA5C3F1, 24'h123456, 24'h0F0F0F);
    group(2'b10, 2'b10, "R2 R6 left-justified 16", 24'h00F00D, 24'h008001, 24'h007FFF);
    group(2'b10, 2'b11, "R6 width code 11", 24'hC0FFEE, 24'h3BEEF1, 24'h010203);
    group(2'b01, 2'b00, "R3 I2S 24", 24'h5A5A5A, 24'hE1E2E3, 24'h800001);
    group(2'b01, 2'b01, "R3 R6 I2S 20", 24'h0ABCDE, 24'h080000, 24'h07FFFF);
    group(2'b00, 2'b00, "R4 right-justified 24", 24'hDEADBE, 24'h600D13, 24'h400000);
    group(2'b00, 2'b10, "R4 R6 right-justified 16", 24'h00BEEF, 24'h001234, 24'h00FFFF);
    group(2'b00, 2'b01, "R4 R6 right-justified 20", 24'h0FEDCB, 24'h000F00, 24'h08ABCD);
    group(2'b11, 2'b00, "R5 DSP 24", 24'h13579B, 24'hFEDCBA, 24'h2468AC);
    group(2'b11, 2'b10, "R5 R6 DSP 16", 24'h00CAFE, 24'h000BAD, 24'h008000);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule